// File: doc/BRIEF.md
# Dual-Clock FIFO with Rewind and Selectable Timing

This block is a first-in first-out buffer for 9-bit words. A producer writes on one clock and a consumer reads on an unrelated clock. The storage depth is a parameter, a power of two with a default of 2048 words. The two pointers cross between the clock domains as Gray codes through multi-flop synchronizers. Each status flag is computed from registered pointers in the domain of the clock that owns it.

The timing mode is latched while master reset is held. In standard mode a word is presented one read clock edge after an enabled read. In fall-through mode the oldest stored word is presented on its own, and a valid bit tells the consumer when it can be taken. A partial reset empties the buffer and keeps the latched mode. A rewind input moves only the read pointer back to storage location zero, so the data written since the last reset can be read again. The write side is not disturbed by a rewind. Rewind is intended for use while fewer than DEPTH words have been written since the last reset.

The almost-full and almost-empty thresholds come from a separate offset register block as plain inputs. A half-full indication is also provided.

Top module: `rtx_fifo`

## Requirements
- R1: Master reset (`mrst_n` low, synchronous, held for at least 4 edges of each clock) sets both pointers to zero and clears `rd_data` to 0. It latches `mode_sel` as the timing mode: 0 selects standard and 1 selects fall-through. After release the flags show an empty buffer.
- R2: Partial reset (`prst_n` low, same timing) sets both pointers to zero and clears `rd_data` to 0. The latched timing mode is kept whatever the value of `mode_sel`.
- R3: In standard mode a read with `rd_en` high and the buffer not empty presents the oldest word on `rd_data` after that read clock edge. Words leave in the order they were written.
- R4: In fall-through mode the oldest stored word appears on `rd_data` with no `rd_en`. A read with `rd_en` high while the word is valid consumes it.
- R5: Write flag `ff_ir_n`. In standard mode it is 0 exactly when the stored count equals DEPTH. In fall-through mode it is 0 exactly when the count is below DEPTH.
- R6: Read flag `ef_or_n`. In standard mode it is 0 exactly when the count is 0. In fall-through mode it is 1 exactly when no valid word is presented.
- R7: A write while the buffer holds DEPTH words is ignored: the stored data is not changed and the write pointer does not move.
- R8: A read while the buffer shows empty is ignored: `rd_data` is not changed and the read pointer does not move.
- R9: `paf_n` is 0 exactly when the count is greater than DEPTH minus `full_off`.
- R10: `pae_n` is 0 exactly when the count is less than `empty_off`.
- R11: `hf_n` is 0 exactly when the count is greater than DEPTH/2.
- R12: `retx` high on a read clock edge sets the read pointer to zero and leaves the write pointer alone. From that edge for RT_HOLD (default 2) read clock cycles the read flag shows empty: `ef_or_n` is 0 in standard mode and 1 in fall-through mode. After that, reads restart from the first word written since the last reset.

Here the count is the number of words written minus the number of words read since the last reset or rewind. It is observed after the crossing latency, that is 4 edges of the other clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low, held across both clocks |
| prst_n | input | 1 | Partial reset, active low, keeps the latched mode |
| mode_sel | input | 1 | Timing mode sampled during master reset (1 = fall-through) |
| wr_en | input | 1 | Write enable, sampled on wr_clk |
| wr_data | input | DW (9) | Write data |
| rd_en | input | 1 | Read enable, sampled on rd_clk |
| retx | input | 1 | Rewind request, sampled on rd_clk |
| full_off | input | AW+1 (12) | Almost-full offset |
| empty_off | input | AW+1 (12) | Almost-empty offset |
| rd_data | output | DW (9) | Output data register |
| ff_ir_n | output | 1 | Full (standard) or input-ready (fall-through) flag, active low |
| ef_or_n | output | 1 | Empty (standard) or output-ready (fall-through) flag, active low |
| paf_n | output | 1 | Almost-full flag, active low |
| pae_n | output | 1 | Almost-empty flag, active low |
| hf_n | output | 1 | Half-full flag, active low |

## Verification
The bench runs on a 16-word build in both timing modes. It fills the buffer one word at a time from empty to full and drains it back to empty, checking every flag against the count at each level. Two pairs of offsets move the almost-full and almost-empty thresholds, so a comparison that is off by one or compares the wrong way shows up as a wrong flag at a single level. Writes into a full buffer and reads from an empty one are followed by a full drain or a single-word round trip, which shows whether a pointer moved that should not have. A partial reset with the mode input inverted, followed by a rewind after a partial drain, tells apart a mode that is kept from one that is resampled. It also tells a rewind to the first word from a rewind to the current read position.

// File: rtl/rtx_fifo_pkg.sv
// Package: shared types for the dual-clock rewind FIFO.
// Assumes: nothing beyond IEEE 1800-2017.
package rtx_fifo_pkg;

    // Timing mode latched at master reset
    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } fifo_mode_e;

    // Default number of read cycles the read flag is held empty after a rewind
    localparam int DEF_RT_HOLD = 2;

endpackage

// File: rtl/rtx_fifo_ram.sv
// Module: simple dual-port storage with a write port on one clock and a
// registered read port on another.
// Assumes: the read port never reads a location in the same window in which
// it is being written (the pointer logic guarantees this).
module rtx_fifo_ram #(
    parameter int AW = 11,
    parameter int DW = 9
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] q
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem [WORDS];

    // Store one word per enabled write edge
    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Output register: cleared by either reset, loaded on an enabled read
    always_ff @(posedge rclk) begin
        if (!rrst_n) begin
            q <= '0;
        end else if (re) begin
            q <= mem[raddr];
        end
    end
endmodule

// File: rtl/rtx_fifo_gray_sync.sv
// Module: carries a Gray-coded pointer into another clock domain through a
// chain of flops and converts it back to binary there.
// Assumes: the source changes its Gray value by at most one bit per source
// clock and drives it from a register.
module rtx_fifo_gray_sync #(
    parameter int W      = 12,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] stage [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First flop captures the asynchronous Gray value
            always_ff @(posedge clk) begin
                if (!rst_n) stage[0] <= '0;
                else        stage[0] <= gray_in;
            end
        end else begin : g_next
            // Later flops settle any metastability
            always_ff @(posedge clk) begin
                if (!rst_n) stage[i] <= '0;
                else        stage[i] <= stage[i-1];
            end
        end
    end

    // Gray to binary conversion of the last stage
    always_comb begin
        bin_out[W-1] = stage[STAGES-1][W-1];
        for (int b = W - 2; b >= 0; b--) begin
            bin_out[b] = bin_out[b+1] ^ stage[STAGES-1][b];
        end
    end
endmodule

// File: rtl/rtx_fifo_wr_ctrl.sv
// Module: write-domain control. Keeps the write pointer, blocks writes into a
// full buffer, and produces the full/input-ready, almost-full and half-full
// flags from the write pointer and the synchronized read pointer.
// Assumes: DEPTH is a power of two; resets are synchronous to clk and held
// for several cycles.
module rtx_fifo_wr_ctrl
    import rtx_fifo_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int AW    = $clog2(DEPTH),
    parameter int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          mode_sel,
    input  logic          wr_en,
    input  logic [PW-1:0] full_off,
    input  logic [PW-1:0] rptr_sync,
    output logic [PW-1:0] wptr,
    output logic [PW-1:0] wgray,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic          ff_ir_n,
    output logic          paf_n,
    output logic          hf_n,
    output logic          is_fwft
);
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);
    localparam logic [PW:0]   DEPTH_X = (PW + 1)'(DEPTH);

    fifo_mode_e    mode_q;
    logic [PW-1:0] wcount;
    logic [PW-1:0] wptr_next;
    logic          full;
    logic          run;

    // Occupancy as seen from the write side
    always_comb begin
        wcount    = wptr - rptr_sync;
        full      = (wcount == DEPTH_P);
        run       = mrst_n && prst_n;
        mem_we    = run && wr_en && !full;
        wptr_next = wptr + PW'(mem_we);
        mem_waddr = wptr[AW-1:0];
    end

    // Pointer and mode registers
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            wptr   <= '0;
            wgray  <= '0;
            mode_q <= fifo_mode_e'(mode_sel);
        end else if (!prst_n) begin
            wptr   <= '0;
            wgray  <= '0;
        end else begin
            wptr   <= wptr_next;
            wgray  <= wptr_next ^ (wptr_next >> 1);
        end
    end

    // Write-side flags, active low
    always_comb begin
        is_fwft = (mode_q == MODE_FWFT);
        ff_ir_n = is_fwft ? full : !full;
        paf_n   = !(({1'b0, wcount} + {1'b0, full_off}) > DEPTH_X);
        hf_n    = !(wcount > HALF_P);
    end
endmodule

// File: rtl/rtx_fifo_rd_ctrl.sv
// Module: read-domain control. Keeps the read pointer, handles rewind,
// drives the storage read port for either timing mode, and produces the
// empty/output-ready and almost-empty flags.
// Assumes: DEPTH is a power of two; resets are synchronous to clk; a rewind
// is issued while fewer than DEPTH words were written since the last reset.
module rtx_fifo_rd_ctrl
    import rtx_fifo_pkg::*;
#(
    parameter int DEPTH   = 2048,
    parameter int RT_HOLD = DEF_RT_HOLD,
    parameter int AW      = $clog2(DEPTH),
    parameter int PW      = AW + 1
) (
    input  logic          clk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          mode_sel,
    input  logic          rd_en,
    input  logic          retx,
    input  logic [PW-1:0] empty_off,
    input  logic [PW-1:0] wptr_sync,
    output logic [PW-1:0] rptr,
    output logic [PW-1:0] rgray,
    output logic          mem_re,
    output logic [AW-1:0] mem_raddr,
    output logic          ef_or_n,
    output logic          pae_n,
    output logic          is_fwft
);
    localparam int HW = $clog2(RT_HOLD + 1);

    fifo_mode_e    mode_q;
    logic [HW-1:0] rt_cnt;
    logic          out_valid;
    logic [PW-1:0] rcount;
    logic [PW-1:0] rptr_next;
    logic          hold;
    logic          empty_raw;
    logic          pop;
    logic          more_next;

    // Occupancy, pop decision and next read address
    always_comb begin
        is_fwft   = (mode_q == MODE_FWFT);
        rcount    = wptr_sync - rptr;
        empty_raw = (rcount == '0);
        hold      = (rt_cnt != '0);
        if (is_fwft) pop = rd_en && out_valid && !retx;
        else         pop = rd_en && !empty_raw && !hold && !retx;
        if (!mrst_n || !prst_n) pop = 1'b0;
        rptr_next = retx ? '0 : (rptr + PW'(pop));
        more_next = (rptr_next != wptr_sync);
        mem_raddr = is_fwft ? rptr_next[AW-1:0] : rptr[AW-1:0];
        mem_re    = is_fwft ? more_next : pop;
    end

    // Pointer, rewind hold counter, presented-word valid bit and mode
    always_ff @(posedge clk) begin
        if (!mrst_n || !prst_n) begin
            rptr      <= '0;
            rgray     <= '0;
            rt_cnt    <= '0;
            out_valid <= 1'b0;
            if (!mrst_n) mode_q <= fifo_mode_e'(mode_sel);
        end else begin
            rptr      <= rptr_next;
            rgray     <= rptr_next ^ (rptr_next >> 1);
            if (retx)      rt_cnt <= HW'(RT_HOLD);
            else if (hold) rt_cnt <= rt_cnt - HW'(1);
            out_valid <= !retx && (rt_cnt <= HW'(1)) && more_next;
        end
    end

    // Read-side flags, active low
    always_comb begin
        ef_or_n = is_fwft ? !out_valid : !(empty_raw || hold);
        pae_n   = !(rcount < empty_off);
    end
endmodule

// File: rtl/rtx_fifo.sv
// Module: top of the dual-clock rewind FIFO. Connects write control, read
// control, the two pointer synchronizers and the storage.
// Assumes: DEPTH is a power of two; mrst_n and prst_n are held low for at
// least 4 edges of each clock; mode_sel is steady while mrst_n is low.
module rtx_fifo
    import rtx_fifo_pkg::*;
#(
    parameter int DEPTH       = 2048,
    parameter int DW          = 9,
    parameter int RT_HOLD     = DEF_RT_HOLD,
    parameter int SYNC_STAGES = 2,
    parameter int AW          = $clog2(DEPTH),
    parameter int PW          = AW + 1
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          mode_sel,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic          retx,
    input  logic [PW-1:0] full_off,
    input  logic [PW-1:0] empty_off,
    output logic [DW-1:0] rd_data,
    output logic          ff_ir_n,
    output logic          ef_or_n,
    output logic          paf_n,
    output logic          pae_n,
    output logic          hf_n
);
    logic [PW-1:0] wptr, wgray, rptr, rgray;
    logic [PW-1:0] wptr_at_r, rptr_at_w;
    logic          mem_we, mem_re;
    logic [AW-1:0] mem_waddr, mem_raddr;
    logic          wr_is_fwft, rd_is_fwft;
    logic          rd_rst_n;

    // Output register clears on either reset
    assign rd_rst_n = mrst_n && prst_n;

    rtx_fifo_wr_ctrl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
        .clk       (wr_clk),
        .mrst_n    (mrst_n),
        .prst_n    (prst_n),
        .mode_sel  (mode_sel),
        .wr_en     (wr_en),
        .full_off  (full_off),
        .rptr_sync (rptr_at_w),
        .wptr      (wptr),
        .wgray     (wgray),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .ff_ir_n   (ff_ir_n),
        .paf_n     (paf_n),
        .hf_n      (hf_n),
        .is_fwft   (wr_is_fwft)
    );

    rtx_fifo_rd_ctrl #(.DEPTH(DEPTH), .RT_HOLD(RT_HOLD), .AW(AW), .PW(PW)) u_rd (
        .clk       (rd_clk),
        .mrst_n    (mrst_n),
        .prst_n    (prst_n),
        .mode_sel  (mode_sel),
        .rd_en     (rd_en),
        .retx      (retx),
        .empty_off (empty_off),
        .wptr_sync (wptr_at_r),
        .rptr      (rptr),
        .rgray     (rgray),
        .mem_re    (mem_re),
        .mem_raddr (mem_raddr),
        .ef_or_n   (ef_or_n),
        .pae_n     (pae_n),
        .is_fwft   (rd_is_fwft)
    );

    rtx_fifo_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
        .clk     (rd_clk),
        .rst_n   (rd_rst_n),
        .gray_in (wgray),
        .bin_out (wptr_at_r)
    );

    rtx_fifo_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
        .clk     (wr_clk),
        .rst_n   (rd_rst_n),
        .gray_in (rgray),
        .bin_out (rptr_at_w)
    );

    rtx_fifo_ram #(.AW(AW), .DW(DW)) u_mem (
        .wclk   (wr_clk),
        .we     (mem_we),
        .waddr  (mem_waddr),
        .wdata  (wr_data),
        .rclk   (rd_clk),
        .rrst_n (rd_rst_n),
        .re     (mem_re),
        .raddr  (mem_raddr),
        .q      (rd_data)
    );
endmodule

// File: rtl/rtx_fifo_chk.sv
// Module: property checker for rtx_fifo, attached with bind below.
// Assumes: it sees the top's pointers and latched modes through the bind.
module rtx_fifo_chk #(
    parameter int DEPTH = 2048,
    parameter int PW    = 12
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          mrst_n,
    input logic          prst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic          retx,
    input logic          ff_ir_n,
    input logic          ef_or_n,
    input logic [PW-1:0] wptr,
    input logic [PW-1:0] rptr,
    input logic [PW-1:0] rptr_at_w,
    input logic          wr_is_fwft,
    input logic          rd_is_fwft
);
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    // R7: a write that meets a full flag leaves the write pointer alone
    assert_no_overflow_R7: assert property (@(posedge wr_clk) disable iff (!mrst_n || !prst_n)
        (wr_en && (wr_is_fwft ? ff_ir_n : !ff_ir_n)) |=> $stable(wptr));

    // R7: write-side occupancy never exceeds the depth
    assert_count_bound_R7: assert property (@(posedge wr_clk) disable iff (!mrst_n || !prst_n)
        ((wptr - rptr_at_w) <= DEPTH_P));

    // R8: a read that meets an empty flag leaves the read pointer alone
    assert_no_underflow_R8: assert property (@(posedge rd_clk) disable iff (!mrst_n || !prst_n)
        (rd_en && !retx && (rd_is_fwft ? ef_or_n : !ef_or_n)) |=> $stable(rptr));

    // R12: a rewind returns the read pointer to zero
    assert_retx_rewind_R12: assert property (@(posedge rd_clk) disable iff (!mrst_n || !prst_n)
        retx |=> (rptr == '0));

    // R12: a rewind shows the empty state on the read flag right after
    assert_retx_flag_R12: assert property (@(posedge rd_clk) disable iff (!mrst_n || !prst_n)
        retx |=> (rd_is_fwft ? ef_or_n : !ef_or_n));
endmodule

bind rtx_fifo rtx_fifo_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
    .wr_clk     (wr_clk),
    .rd_clk     (rd_clk),
    .mrst_n     (mrst_n),
    .prst_n     (prst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .retx       (retx),
    .ff_ir_n    (ff_ir_n),
    .ef_or_n    (ef_or_n),
    .wptr       (wptr),
    .rptr       (rptr),
    .rptr_at_w  (rptr_at_w),
    .wr_is_fwft (wr_is_fwft),
    .rd_is_fwft (rd_is_fwft)
);

// File: tb/rtx_fifo_tb.sv
// Bench: sweeps every fill level of a 16-word build in both timing modes.
module rtx_fifo_tb;
    localparam int D  = 16;
    localparam int PW = 5;

    logic          wr_clk = 0, rd_clk = 0;
    logic          mrst_n = 0, prst_n = 1, mode_sel = 0;
    logic          wr_en = 0, rd_en = 0, retx = 0;
    logic [8:0]    wr_data = '0;
    logic [PW-1:0] full_off = 5'd3, empty_off = 5'd4;
    logic [8:0]    rd_data;
    logic          ff_ir_n, ef_or_n, paf_n, pae_n, hf_n;
    int            checks = 0, errors = 0;

    always #4   wr_clk = ~wr_clk;
    always #5.5 rd_clk = ~rd_clk;

    rtx_fifo #(.DEPTH(D)) u_dut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n),
        .mode_sel(mode_sel), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .retx(retx), .full_off(full_off), .empty_off(empty_off), .rd_data(rd_data),
        .ff_ir_n(ff_ir_n), .ef_or_n(ef_or_n), .paf_n(paf_n), .pae_n(pae_n), .hf_n(hf_n)
    );

    function automatic logic [8:0] val(int k);
        return 9'((k * 37 + 5) % 512);
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge rd_clk);
        repeat (6) @(negedge wr_clk);
    endtask

    task automatic do_reset(input bit master, input bit m);
        if (master) mrst_n = 0; else prst_n = 0;
        mode_sel = m;
        repeat (5) @(negedge wr_clk);
        repeat (5) @(negedge rd_clk);
        mrst_n = 1; prst_n = 1;
        settle();
    endtask

    task automatic push(input logic [8:0] v);
        @(negedge wr_clk); wr_en = 1; wr_data = v;
        @(negedge wr_clk); wr_en = 0;
    endtask

    task automatic pop(input int m, output logic [8:0] got);
        if (m == 0) begin
            @(negedge rd_clk); rd_en = 1;
            @(negedge rd_clk); rd_en = 0; got = rd_data;
        end else begin
            @(negedge rd_clk); got = rd_data; rd_en = 1;
            @(negedge rd_clk); rd_en = 0;
        end
    endtask

    // Expected flag values at occupancy k, from R5, R6, R9, R10, R11
    task automatic check_flags(input int m, input int k);
        check("R5 ff_ir_n",  16'(m ? (k == D) : (k != D)), 16'(ff_ir_n));
        check("R6 ef_or_n",  16'(m ? (k == 0) : (k != 0)), 16'(ef_or_n));
        check("R9 paf_n",    16'(!(k > D - int'(full_off))), 16'(paf_n));
        check("R10 pae_n",   16'(!(k < int'(empty_off))), 16'(pae_n));
        check("R11 hf_n",    16'(!(k > D / 2)), 16'(hf_n));
    endtask

    task automatic sweep(input int m);
        logic [8:0] got;
        int base;
        base = 40 * m;
        do_reset(1, m[0]);
        mode_sel = !m[0];
        check("R1 rd_data after master reset", 16'(rd_data), 16'd0);
        check("R1 ef_or_n after master reset", 16'(ef_or_n), 16'(m));
        check_flags(m, 0);
        for (int k = 1; k <= D; k++) begin
            push(val(base + k - 1));
            settle();
            check_flags(m, k);
            if (m == 1) check("R4 first word shown without read", 16'(rd_data), 16'(val(base)));
        end
        for (int i = 0; i < 3; i++) push(9'h1AA);
        settle();
        check_flags(m, D);
        for (int i = 0; i < D; i++) begin
            pop(m, got);
            check(m ? "R4 fall-through order" : "R3 standard order", 16'(got), 16'(val(base + i)));
            settle();
            check_flags(m, D - 1 - i);
        end
        @(negedge rd_clk); rd_en = 1;
        @(negedge rd_clk); rd_en = 0;
        settle();
        check("R8 rd_data kept on empty read", 16'(rd_data), 16'(val(base + D - 1)));
        check_flags(m, 0);
        push(9'h055);
        settle();
        pop(m, got);
        check("R8 pointer unmoved by empty read", 16'(got), 16'h055);
        settle();
        check_flags(m, 0);
    endtask

    task automatic rewind(input int m);
        logic [8:0] got;
        do_reset(0, !m[0]);
        check("R2 rd_data cleared by partial reset", 16'(rd_data), 16'd0);
        check("R2 mode kept by partial reset", 16'(ef_or_n), 16'(m));
        for (int i = 0; i < 6; i++) push(val(200 + i));
        settle();
        for (int i = 0; i < 3; i++) begin
            pop(m, got);
            check("R12 reads before rewind", 16'(got), 16'(val(200 + i)));
        end
        @(negedge rd_clk); retx = 1;
        @(negedge rd_clk); retx = 0;
        check("R12 read flag forced empty", 16'(ef_or_n), 16'(m));
        settle();
        check_flags(m, 6);
        for (int i = 0; i < 6; i++) begin
            pop(m, got);
            check("R12 reread from first word", 16'(got), 16'(val(200 + i)));
        end
        settle();
        check_flags(m, 0);
    endtask

    initial begin
        full_off = 5'd3; empty_off = 5'd4;
        sweep(0);
        rewind(0);
        full_off = 5'd5; empty_off = 5'd2;
        sweep(1);
        rewind(1);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge wr_clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule